// File: doc/BRIEF.md
# External Bus Master Access Front-End

This block lets masters outside the chip reach memory through the on-chip chip-select and acknowledge logic. It accepts two kinds of request. A clock-synchronous master raises a start strobe for one rising edge. An asynchronous master raises an address strobe and holds it for the whole access. That strobe passes through a two-flop synchronizer, and each new assertion starts exactly one access.

Both request paths share one decoder with four programmable banks. Each bank has a valid bit, a base, a mask and a 3-bit attribute. External requests always present attribute 100 to the decoder. On a hit the block drives one chip-select, a write or a read enable, and the transfer acknowledge. A synchronous access is acknowledged after a programmed wait of 0 to 3 clocks, and it can run as a 4-beat burst. A 3-bit burst-address output mirrors address bits [3:1] for internal masters. For external masters it mirrors them on the first beat only and then steps through the wrapped burst order.

Top module: `ext_master_frontend`

## Requirements
- R1: While `sync_en_i` is 0, a `ts_i` pulse starts no access: `cs_o`, `ta_o`, `we_o` and `oe_o` stay 0.
- R2: While `async_en_i` is 0, an `as_i` assertion starts no access: `cs_o`, `ta_o`, `we_o` and `oe_o` stay 0.
- R3: A synchronous access starts when `ts_i` is sampled at 1 on a rising edge and the address hits a bank. `cs_o` is driven in the cycle after that edge. `ta_o` is high for exactly one cycle, in cycle index `wait_cnt_i` counted from 0 at that first cycle.
- R4: Bank g hits when its valid bit is 1, when `(addr_i ^ base[g]) & mask[g]` is zero, and when its attribute equals 3'b100. When several banks hit, the lowest index wins. `cs_o[g]` is the one-hot select.
- R5: An address that hits no bank produces no `cs_o` bit and no `ta_o`.
- R6: The asynchronous path works as follows. Say `as_i` is first sampled high at edge E0. Then `cs_o`, the enable and `ta_o` turn on after edge E2. They turn off after the second edge that samples `as_i` low, and one strobe assertion gives one access.
- R7: When `burst_i` is 1 at the start, a synchronous access runs 4 beats, each acknowledged after the wait count. Bits [2:1] of `baddr_o` count up modulo 4 from the start value, and bit 0 stays as captured.
- R8: While `int_own_i` is 1, `baddr_o` equals `addr_i[3:1]` in every cycle, including during an external access.
- R9: On the first beat of an external access, `baddr_o` equals `addr_i[3:1]`.
- R10: During an access, `we_o` is 1 for writes (`wr_i`=1) and `oe_o` is 1 for reads. They are never on together.
- R11: During and right after reset, all control outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sync_en_i | input | 1 | Enable for synchronous external masters |
| async_en_i | input | 1 | Enable for asynchronous external masters |
| wait_cnt_i | input | WAIT_W | Wait clocks before each synchronous acknowledge |
| bank_valid_i | input | NBANK | Per-bank valid bit |
| bank_base_i | input | NBANK x AW | Per-bank base address |
| bank_mask_i | input | NBANK x AW | Per-bank compare mask |
| bank_attr_i | input | NBANK x 3 | Per-bank attribute match value |
| ts_i | input | 1 | Synchronous transfer-start strobe |
| as_i | input | 1 | Asynchronous address strobe |
| addr_i | input | AW | Request address |
| wr_i | input | 1 | 1 = write, 0 = read |
| burst_i | input | 1 | Request a 4-beat burst (synchronous only) |
| int_own_i | input | 1 | Internal master owns the bus |
| cs_o | output | NBANK | One-hot chip-select |
| we_o | output | 1 | Write enable |
| oe_o | output | 1 | Read (output) enable |
| ta_o | output | 1 | Transfer acknowledge |
| baddr_o | output | 3 | Burst address bits |

## Verification
The bench builds the block with its defaults: four banks, 32-bit addresses and a 2-bit wait count. This makes every wait value from 0 to 3 reachable. The banks are programmed with overlap (bank 0 sits inside bank 3's range), one invalid bank, and one bank whose attribute is not 100. Priority, validity and attribute forcing each decide some accesses. A start field of 3'b110 makes the 4-beat burst wrap across zero, and a second burst with the internal-ownership input held high separates the two burst-address sources.

// File: rtl/ext_mst_pkg.sv
package ext_mst_pkg;
  localparam logic [2:0] ATTR_EXT = 3'b100;
  localparam int ATTR_W = 3;
  localparam int BA_W   = 3;
  localparam int BA_LSB = 1;
  localparam int BEAT_W = BA_W - 1;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SYNC,
    ST_ASYNC
  } xfer_st_e;
endpackage

// File: rtl/ext_bank_match.sv
module ext_bank_match
  import ext_mst_pkg::*;
#(
  parameter int AW    = 32,
  parameter int NBANK = 4
) (
  input  logic [AW-1:0]                 addr_i,
  input  logic [ATTR_W-1:0]             attr_i,
  input  logic [NBANK-1:0]              bank_valid_i,
  input  logic [NBANK-1:0][AW-1:0]      bank_base_i,
  input  logic [NBANK-1:0][AW-1:0]      bank_mask_i,
  input  logic [NBANK-1:0][ATTR_W-1:0]  bank_attr_i,
  output logic [NBANK-1:0]              sel_o,
  output logic                          hit_o
);
  logic [NBANK-1:0] raw;

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    assign raw[g] = bank_valid_i[g]
                 && (((addr_i ^ bank_base_i[g]) & bank_mask_i[g]) == '0)
                 && (attr_i == bank_attr_i[g]);
  end

  // isolate lowest set bit: bank 0 has priority
  assign sel_o = raw & (~raw + {{(NBANK-1){1'b0}}, 1'b1});
  assign hit_o = |raw;
endmodule

// File: rtl/ext_as_sync.sv
module ext_as_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic as_i,
  output logic lvl_o,
  output logic rise_o
);
  logic s1_q, s2_q, s3_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
      s3_q <= 1'b0;
    end else begin
      s1_q <= as_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign lvl_o  = s2_q;
  assign rise_o = s2_q & ~s3_q;
endmodule

// File: rtl/ext_burst_addr.sv
module ext_burst_addr
  import ext_mst_pkg::*;
(
  input  logic              int_own_i,
  input  logic              ext_act_i,
  input  logic [BA_W-1:0]   addr_fld_i,
  input  logic [BA_W-1:0]   start_fld_i,
  input  logic [BEAT_W-1:0] beat_i,
  output logic [BA_W-1:0]   baddr_o
);
  logic [BEAT_W-1:0] wrap;
  logic [BA_W-1:0]   seq;

  assign wrap = start_fld_i[BA_W-1 -: BEAT_W] + beat_i;
  assign seq  = {wrap, start_fld_i[BA_W-BEAT_W-1:0]};

  always_comb begin
    if (int_own_i || !ext_act_i) baddr_o = addr_fld_i;
    else                         baddr_o = seq;
  end
endmodule

// File: rtl/ext_master_frontend.sv
module ext_master_frontend
  import ext_mst_pkg::*;
#(
  parameter int AW     = 32,
  parameter int NBANK  = 4,
  parameter int WAIT_W = 2
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          sync_en_i,
  input  logic                          async_en_i,
  input  logic [WAIT_W-1:0]             wait_cnt_i,
  input  logic [NBANK-1:0]              bank_valid_i,
  input  logic [NBANK-1:0][AW-1:0]      bank_base_i,
  input  logic [NBANK-1:0][AW-1:0]      bank_mask_i,
  input  logic [NBANK-1:0][ATTR_W-1:0]  bank_attr_i,
  input  logic                          ts_i,
  input  logic                          as_i,
  input  logic [AW-1:0]                 addr_i,
  input  logic                          wr_i,
  input  logic                          burst_i,
  input  logic                          int_own_i,
  output logic [NBANK-1:0]              cs_o,
  output logic                          we_o,
  output logic                          oe_o,
  output logic                          ta_o,
  output logic [BA_W-1:0]               baddr_o
);
  localparam logic [BEAT_W-1:0] LAST_BEAT = {BEAT_W{1'b1}};

  xfer_st_e          state_q;
  logic [NBANK-1:0]  sel_q, sel;
  logic              hit, wr_q, burst_q;
  logic [WAIT_W-1:0] cnt_q, wait_q;
  logic [BEAT_W-1:0] beat_q;
  logic [BA_W-1:0]   start_q;
  logic              as_lvl, as_rise;
  logic              sync_go, async_go, sync_act, async_on, xfer_on;

  ext_bank_match #(.AW(AW), .NBANK(NBANK)) u_match (
    .addr_i      (addr_i),
    .attr_i      (ATTR_EXT),
    .bank_valid_i(bank_valid_i),
    .bank_base_i (bank_base_i),
    .bank_mask_i (bank_mask_i),
    .bank_attr_i (bank_attr_i),
    .sel_o       (sel),
    .hit_o       (hit)
  );

  ext_as_sync u_as_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .as_i  (as_i),
    .lvl_o (as_lvl),
    .rise_o(as_rise)
  );

  assign sync_go  = (state_q == ST_IDLE) && sync_en_i && ts_i && hit;
  assign async_go = (state_q == ST_IDLE) && async_en_i && as_rise && hit && !sync_go;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      sel_q   <= '0;
      wr_q    <= 1'b0;
      burst_q <= 1'b0;
      cnt_q   <= '0;
      wait_q  <= '0;
      beat_q  <= '0;
      start_q <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (sync_go || async_go) begin
            state_q <= sync_go ? ST_SYNC : ST_ASYNC;
            sel_q   <= sel;
            wr_q    <= wr_i;
            burst_q <= sync_go & burst_i;
            cnt_q   <= sync_go ? wait_cnt_i : '0;
            wait_q  <= wait_cnt_i;
            beat_q  <= '0;
            start_q <= addr_i[BA_LSB +: BA_W];
          end
        end
        ST_SYNC: begin
          if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
          end else if (burst_q && beat_q != LAST_BEAT) begin
            beat_q <= beat_q + 1'b1;
            cnt_q  <= wait_q;
          end else begin
            state_q <= ST_IDLE;
          end
        end
        ST_ASYNC: begin
          if (!as_lvl) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // async outputs drop with the synchronized strobe, not a cycle later
  assign sync_act = (state_q == ST_SYNC);
  assign async_on = (state_q == ST_ASYNC) && as_lvl;
  assign xfer_on  = sync_act || async_on;

  assign cs_o = xfer_on ? sel_q : '0;
  assign we_o = xfer_on && wr_q;
  assign oe_o = xfer_on && !wr_q;
  assign ta_o = (sync_act && cnt_q == '0) || async_on;

  ext_burst_addr u_baddr (
    .int_own_i  (int_own_i),
    .ext_act_i  (state_q != ST_IDLE),
    .addr_fld_i (addr_i[BA_LSB +: BA_W]),
    .start_fld_i(start_q),
    .beat_i     (beat_q),
    .baddr_o    (baddr_o)
  );

  AST_SYNC_DISABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && !sync_en_i && !(async_en_i && as_rise)) |=> state_q == ST_IDLE); // R1
  AST_TA_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_act && ta_o && !burst_q) |=> !ta_o); // R3
  AST_CS_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(cs_o)); // R4
  AST_TA_NEEDS_CS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ta_o |-> (cs_o != '0)); // R5
  AST_ASYNC_NEGATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ASYNC && $fell(as_lvl)) |-> (!ta_o && cs_o == '0 && !we_o && !oe_o)); // R6
  AST_FIRST_BEAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_act && beat_q == '0 && !int_own_i) |-> baddr_o == addr_i[BA_LSB +: BA_W]); // R9
  AST_EN_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_o && oe_o)); // R10
endmodule

// File: tb/ext_master_frontend_tb.sv
module ext_master_frontend_tb;
  localparam int AW = 32, NBANK = 4, WAIT_W = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sync_en = 1'b1, async_en = 1'b1;
  logic [WAIT_W-1:0] wait_cnt = '0;
  logic [NBANK-1:0] bank_valid;
  logic [NBANK-1:0][AW-1:0] bank_base, bank_mask;
  logic [NBANK-1:0][2:0] bank_attr;
  logic ts = 1'b0, as_s = 1'b0, wr = 1'b0, burst = 1'b0, int_own = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [NBANK-1:0] cs;
  logic we, oe, ta;
  logic [2:0] baddr;
  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  ext_master_frontend #(.AW(AW), .NBANK(NBANK), .WAIT_W(WAIT_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .sync_en_i(sync_en), .async_en_i(async_en),
    .wait_cnt_i(wait_cnt), .bank_valid_i(bank_valid), .bank_base_i(bank_base),
    .bank_mask_i(bank_mask), .bank_attr_i(bank_attr), .ts_i(ts), .as_i(as_s),
    .addr_i(addr), .wr_i(wr), .burst_i(burst), .int_own_i(int_own),
    .cs_o(cs), .we_o(we), .oe_o(oe), .ta_o(ta), .baddr_o(baddr)
  );

  typedef struct packed {
    logic [31:0] addr;
    logic        wr;
    logic [1:0]  w;
    logic [3:0]  cs;
  } vec_t;

  // bank0 0x30xx (inside bank3 0x3xxx), bank1 invalid 0x4xxx, bank2 wrong attribute 0x2xxx
  localparam vec_t VECS [8] = '{
    '{32'h3012_3456, 1'b1, 2'd0, 4'b0001},
    '{32'h3512_0000, 1'b0, 2'd1, 4'b1000},
    '{32'h4000_0010, 1'b1, 2'd2, 4'b0000},
    '{32'h2000_0000, 1'b0, 2'd0, 4'b0000},
    '{32'h5000_0000, 1'b0, 2'd3, 4'b0000},
    '{32'h30FF_000A, 1'b0, 2'd3, 4'b0001},
    '{32'h3F00_0006, 1'b1, 2'd2, 4'b1000},
    '{32'h0000_0000, 1'b1, 2'd1, 4'b0000}
  };

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic idle_outputs(input string req, input int cycles);
    for (int k = 0; k < cycles; k++) begin
      @(negedge clk);
      check(req, "outputs idle", {cs, we, oe, ta}, '0);
    end
  endtask

  task automatic do_sync(input vec_t v);
    logic hit = (v.cs != '0);
    int ta_cnt = 0, ta_at = -1;
    @(negedge clk);
    ts = 1'b1; addr = v.addr; wr = v.wr; wait_cnt = v.w; burst = 1'b0;
    @(negedge clk);
    ts = 1'b0;
    check(hit ? "R4" : "R5", "cs first cycle", cs, v.cs);
    check("R10", "we/oe", {we, oe}, {hit & v.wr, hit & ~v.wr});
    check("R9", "baddr first beat", baddr, v.addr[3:1]);
    for (int k = 0; k < 5; k++) begin
      if (k > 0) @(negedge clk);
      if (ta) begin ta_cnt++; ta_at = k; end
    end
    check(hit ? "R3" : "R5", "ta count", ta_cnt, hit ? 1 : 0);
    if (hit) check("R3", "ta cycle", ta_at, v.w);
    @(negedge clk);
  endtask

  task automatic do_burst(input logic own);
    int nta = 0;
    logic [2:0] exp_b [4] = '{3'd6, 3'd0, 3'd2, 3'd4};
    @(negedge clk);
    ts = 1'b1; addr = 32'h3512_000C; wr = 1'b0; wait_cnt = 2'd1; burst = 1'b1; int_own = own;
    @(negedge clk);
    ts = 1'b0; burst = 1'b0;
    for (int k = 0; k < 10; k++) begin
      if (k > 0) @(negedge clk);
      check("R7", "burst ta", ta, (k % 2 == 1) && k < 8);
      if (ta && nta < 4) begin
        check(own ? "R8" : "R7", "burst baddr", baddr, own ? 3'd6 : exp_b[nta]);
        nta++;
      end
    end
    check("R7", "burst beats", nta, 4);
    int_own = 1'b0;
  endtask

  task automatic do_async(input logic [31:0] a, input logic w, input logic [3:0] exp_cs,
                          input string req);
    logic hit = (exp_cs != '0);
    @(negedge clk);
    as_s = 1'b1; addr = a; wr = w;
    @(negedge clk);
    check(req, "async pre-sync n0", {cs, ta}, '0);
    @(negedge clk);
    check(req, "async pre-sync n1", {cs, ta}, '0);
    @(negedge clk);
    check(req, "async on cs", cs, exp_cs);
    check(req, "async on ta", ta, hit);
    check("R10", "async we/oe", {we, oe}, {hit & w, hit & ~w});
    repeat (3) @(negedge clk);
    check(req, "async held", {cs, ta}, {exp_cs, hit});
    as_s = 1'b0;
    @(negedge clk);
    check(req, "async still on", {cs, ta}, {exp_cs, hit});
    @(negedge clk);
    check("R6", "async negated", {cs, we, oe, ta}, '0);
    idle_outputs("R6", 4);
  endtask

  initial begin
    bank_valid = 4'b1101;
    bank_base  = '{32'h3000_0000, 32'h2000_0000, 32'h4000_0000, 32'h3000_0000};
    bank_mask  = '{32'hF000_0000, 32'hF000_0000, 32'hF000_0000, 32'hFF00_0000};
    bank_attr  = '{3'b100, 3'b010, 3'b100, 3'b100};
    addr = 32'h3012_3456; ts = 1'b0;
    repeat (3) @(negedge clk);
    check("R11", "outputs in reset", {cs, we, oe, ta}, '0);
    rst_n = 1'b1;
    idle_outputs("R11", 2);

    foreach (VECS[i]) do_sync(VECS[i]);

    sync_en = 1'b0;
    @(negedge clk);
    ts = 1'b1; addr = 32'h3012_0000; wr = 1'b1; wait_cnt = 2'd0;
    @(negedge clk);
    ts = 1'b0;
    check("R1", "disabled sync", {cs, we, oe, ta}, '0);
    idle_outputs("R1", 5);
    sync_en = 1'b1;

    do_burst(1'b0);
    do_burst(1'b1);

    @(negedge clk);
    int_own = 1'b1; addr = 32'h3000_000E;
    @(negedge clk);
    check("R8", "idle mirror", baddr, 3'd7);
    addr = 32'h3000_0002;
    @(negedge clk);
    check("R8", "idle mirror 2", baddr, 3'd1);
    int_own = 1'b0;

    do_async(32'h3512_0000, 1'b1, 4'b1000, "R6");
    do_async(32'h3001_0000, 1'b0, 4'b0001, "R4");
    do_async(32'h2000_0000, 1'b0, 4'b0000, "R5");

    async_en = 1'b0;
    do_async(32'h3512_0000, 1'b1, 4'b0000, "R2");
    async_en = 1'b1;

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog (all): actual=timeout expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
      $finish;
    end
  end
endmodule